// File: doc/BRIEF.md
# Carry-Linked Oscillator Frequency Control Word and Power-of-Two Divider

This block holds the frequency control state of a digitally controlled oscillator. The state has two parts: a stage word and a divider exponent. The stage word is split into a coarse stage select and a fine dither count, and a downstream fine-adjust sequencer reads it. The divider exponent sets how many oscillator enables go into one output enable.

A loop filter changes the stage word by presenting a signed step for one cycle. The loop filter has no direct path to the exponent. The exponent moves up by one when the addition overflows past the top of the stage word. It moves down by one when a subtraction underflows below zero. When the exponent is already at its ceiling or floor, the stage word clamps instead of wrapping.

An incoming oscillator clock-enable stream is divided by two raised to the exponent. A free-running counter does the division. It picks up a new exponent only when it wraps, so a changed ratio never produces a shortened output period.

Top module: `dcoctl_top`

## Requirements
- R1: Synchronous active-low reset clears the stage word and the exponent to zero. The first oscillator enable after reset produces an output enable (divide by one).
- R2: A loop update (`lf_valid` high for one cycle) whose signed two's-complement step keeps the sum within 0..255 loads that sum into the stage word and leaves the exponent unchanged.
- R3: An update whose sum exceeds 255 while the exponent is below 9 loads the sum minus 256 into the stage word and raises the exponent by one.
- R4: An update whose sum falls below 0 while the exponent is above 0 loads the sum plus 256 into the stage word and lowers the exponent by one.
- R5: An update whose sum exceeds 255 while the exponent is 9 sets the stage word to 255 and leaves the exponent at 9. The exponent never exceeds 9.
- R6: An update whose sum falls below 0 while the exponent is 0 sets the stage word to 0 and leaves the exponent at 0.
- R7: `coarse_sel` equals stage word bits 7:5 and `fine_cnt` equals stage word bits 4:0.
- R8: `div_en` is asserted only in cycles where `osc_en` is high. Exactly one of every 2^exponent oscillator enables produces an output enable, whatever the spacing between the oscillator enables.
- R9: An exponent change takes effect at the next output enable. The period already in progress completes with the old ratio, and the following period uses the new ratio.
- R10: The divider treats exponent codes 10 through 15 exactly like code 9, giving a ratio of 512.
- R11: While `lf_valid` is low, the stage word and the exponent hold their values, whatever `lf_step` carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_valid | input | 1 | Loop-filter update strobe |
| lf_step | input | 6 | Signed step added to the stage word |
| osc_en | input | 1 | Oscillator clock-enable stream |
| stage_word | output | 8 | Current stage control word |
| coarse_sel | output | 3 | Coarse stage select (stage word bits 7:5) |
| fine_cnt | output | 5 | Fine dither count (stage word bits 4:0) |
| div_exp | output | 4 | Current divider exponent |
| div_en | output | 1 | Divided output enable |

## Verification
The bench builds the top module with its default parameters: an 8-bit stage word, a 6-bit step and a ceiling of 9. With these values, stepping by the largest positive and negative steps climbs the full exponent ladder in under a hundred updates and brings it back down again. It also reaches both clamp conditions. Because the longest period is 512 enables, the ratio can be measured after every exponent change. A second, standalone divider instance takes its exponent straight from the bench, which makes codes 10 to 15 reachable. Those codes cannot arise through the carry path.

// File: rtl/dcoctl_pkg.sv
// Shared definitions for the oscillator control word block.
package dcoctl_pkg;

    // Exponent adjustment requested by the stage accumulator.
    typedef enum logic [1:0] {
        ADJ_NONE = 2'd0,
        ADJ_UP   = 2'd1,
        ADJ_DOWN = 2'd2
    } adj_e;

endpackage

// File: rtl/dcoctl_stage_acc.sv
// Stage word accumulator.
// Adds a signed loop step to the stage word. On an overflow out of the top
// it either wraps and asks for an exponent increment, or clamps to all ones
// when the exponent is at its ceiling. Underflow is handled the same way
// toward zero.
// Assumes STEP_W <= STAGE_W + 1, so a single step can cross at most one
// boundary.
module dcoctl_stage_acc
    import dcoctl_pkg::*;
#(
    parameter int STAGE_W = 8,
    parameter int STEP_W  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               upd_valid,
    input  logic [STEP_W-1:0]  upd_step,
    input  logic               exp_at_max,
    input  logic               exp_at_min,
    output logic [STAGE_W-1:0] stage_q,
    output adj_e               adj
);

    localparam int EXT_W = STAGE_W + 2;

    logic [EXT_W-1:0]   sum_x;
    logic               ovf_up;
    logic               ovf_dn;
    logic [STAGE_W-1:0] stage_d;

    // Extended-width sum of the current word and the sign-extended step.
    always_comb begin
        sum_x = {2'b00, stage_q} + {{(EXT_W-STEP_W){upd_step[STEP_W-1]}}, upd_step};
    end

    // Classify the sum: above the top, below zero, or in range.
    always_comb begin
        ovf_dn = sum_x[EXT_W-1];
        ovf_up = !sum_x[EXT_W-1] && sum_x[STAGE_W];
    end

    // Choose the next stage word and the exponent request.
    always_comb begin
        stage_d = stage_q;
        adj     = ADJ_NONE;
        if (upd_valid) begin
            if (ovf_up) begin
                if (exp_at_max) begin
                    stage_d = '1;
                end else begin
                    stage_d = sum_x[STAGE_W-1:0];
                    adj     = ADJ_UP;
                end
            end else if (ovf_dn) begin
                if (exp_at_min) begin
                    stage_d = '0;
                end else begin
                    stage_d = sum_x[STAGE_W-1:0];
                    adj     = ADJ_DOWN;
                end
            end else begin
                stage_d = sum_x[STAGE_W-1:0];
            end
        end
    end

    // Stage word register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

endmodule

// File: rtl/dcoctl_exp_reg.sv
// Divider exponent register.
// Moves by one step in response to the accumulator's request and saturates
// at 0 and EXP_MAX. It also reports whether either limit is reached, so
// that the accumulator can clamp the stage word instead.
// Assumes EXP_MAX fits in EXP_W bits.
module dcoctl_exp_reg
    import dcoctl_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  adj_e             adj,
    output logic [EXP_W-1:0] exp_q,
    output logic             at_max,
    output logic             at_min
);

    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

    // Limit flags that the accumulator uses.
    always_comb begin
        at_max = (exp_q >= EXP_TOP);
        at_min = (exp_q == '0);
    end

    // Exponent update, saturating at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_q <= '0;
        end else begin
            unique case (adj)
                ADJ_UP:   if (!at_max) exp_q <= exp_q + EXP_W'(1);
                ADJ_DOWN: if (!at_min) exp_q <= exp_q - EXP_W'(1);
                default:  exp_q <= exp_q;
            endcase
        end
    end

endmodule

// File: rtl/dcoctl_pow2_div.sv
// Power-of-two enable divider.
// A free-running counter advances on each input enable. When it reaches
// 2^exp - 1, the same enable is passed to the output and the counter wraps.
// A requested exponent is latched only at a wrap, so every output period is
// complete. Requested codes above EXP_MAX are treated as EXP_MAX.
// Assumes EXP_MAX >= 1.
module dcoctl_pow2_div #(
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXP_W-1:0] exp_req,
    input  logic             in_en,
    output logic             out_en
);

    localparam int CNT_W = (EXP_MAX < 1) ? 1 : EXP_MAX;
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

    logic [EXP_W-1:0] req_clamped;
    logic [EXP_W-1:0] cur_exp;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] mask;
    logic             wrap;

    // Clamp out-of-range exponent codes to the ceiling.
    always_comb begin
        req_clamped = (exp_req > EXP_TOP) ? EXP_TOP : exp_req;
    end

    // Terminal count mask: the low cur_exp bits set.
    for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
        assign mask[gi] = (cur_exp > EXP_W'(gi));
    end

    // The last enable of a period wraps the counter and is passed through.
    always_comb begin
        wrap   = in_en && (cnt_q == mask);
        out_en = wrap;
    end

    // Counter and active exponent, which is reloaded only at a wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            cur_exp <= '0;
        end else if (in_en) begin
            if (wrap) begin
                cnt_q   <= '0;
                cur_exp <= req_clamped;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/dcoctl_top.sv
// Oscillator frequency control word with carry-linked divider exponent.
// The loop filter adjusts only the stage word. Overflow and underflow of
// that word step the exponent, which in turn sets the power-of-two ratio
// applied to the oscillator enable stream.
// Assumes the step is narrower than the stage word plus one bit, and that
// COARSE_W < STAGE_W.
module dcoctl_top
    import dcoctl_pkg::*;
#(
    parameter int STAGE_W  = 8,
    parameter int COARSE_W = 3,
    parameter int STEP_W   = 6,
    parameter int EXP_W    = 4,
    parameter int EXP_MAX  = 9
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        lf_valid,
    input  logic [STEP_W-1:0]           lf_step,
    input  logic                        osc_en,
    output logic [STAGE_W-1:0]          stage_word,
    output logic [COARSE_W-1:0]         coarse_sel,
    output logic [STAGE_W-COARSE_W-1:0] fine_cnt,
    output logic [EXP_W-1:0]            div_exp,
    output logic                        div_en
);

    localparam int FINE_W = STAGE_W - COARSE_W;

    adj_e adj;
    logic exp_at_max;
    logic exp_at_min;

    dcoctl_stage_acc #(
        .STAGE_W (STAGE_W),
        .STEP_W  (STEP_W)
    ) acc_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd_valid  (lf_valid),
        .upd_step   (lf_step),
        .exp_at_max (exp_at_max),
        .exp_at_min (exp_at_min),
        .stage_q    (stage_word),
        .adj        (adj)
    );

    dcoctl_exp_reg #(
        .EXP_W   (EXP_W),
        .EXP_MAX (EXP_MAX)
    ) exp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .adj    (adj),
        .exp_q  (div_exp),
        .at_max (exp_at_max),
        .at_min (exp_at_min)
    );

    dcoctl_pow2_div #(
        .EXP_W   (EXP_W),
        .EXP_MAX (EXP_MAX)
    ) div_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .exp_req (div_exp),
        .in_en   (osc_en),
        .out_en  (div_en)
    );

    // Split the stage word for the fine-adjust sequencer.
    always_comb begin
        coarse_sel = stage_word[STAGE_W-1:FINE_W];
        fine_cnt   = stage_word[FINE_W-1:0];
    end

endmodule

// File: rtl/dcoctl_chk.sv
// Assertion checker for dcoctl_top. It observes the ports only and is
// attached through bind.
module dcoctl_chk #(
    parameter int STAGE_W = 8,
    parameter int STEP_W  = 6,
    parameter int EXP_W   = 4,
    parameter int EXP_MAX = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lf_valid,
    input logic [STEP_W-1:0]  lf_step,
    input logic               osc_en,
    input logic [STAGE_W-1:0] stage_word,
    input logic [EXP_W-1:0]   div_exp,
    input logic               div_en
);

    localparam int EXT_W = STAGE_W + 2;
    localparam logic [EXP_W-1:0] EXP_TOP = EXP_W'(EXP_MAX);

    logic [EXT_W-1:0] trial;
    logic             t_up;
    logic             t_dn;

    // Sum as seen from the ports, used to classify each update.
    always_comb begin
        trial = {2'b00, stage_word} + {{(EXT_W-STEP_W){lf_step[STEP_W-1]}}, lf_step};
        t_dn  = trial[EXT_W-1];
        t_up  = !trial[EXT_W-1] && trial[STAGE_W];
    end

    p_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lf_valid && t_up && (div_exp < EXP_TOP) |=> div_exp == $past(div_exp) + EXP_W'(1));

    p_borrow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        lf_valid && t_dn && (div_exp != '0) |=> div_exp == $past(div_exp) - EXP_W'(1));

    p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        lf_valid && t_up && (div_exp == EXP_TOP) |=> (stage_word == '1) && $stable(div_exp));

    p_exp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        div_exp <= EXP_TOP);

    p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lf_valid && t_dn && (div_exp == '0) |=> (stage_word == '0) && (div_exp == '0));

    p_gated_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_en |-> osc_en);

    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !lf_valid |=> $stable(stage_word) && $stable(div_exp));

endmodule

bind dcoctl_top dcoctl_chk #(
    .STAGE_W (STAGE_W),
    .STEP_W  (STEP_W),
    .EXP_W   (EXP_W),
    .EXP_MAX (EXP_MAX)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .lf_valid   (lf_valid),
    .lf_step    (lf_step),
    .osc_en     (osc_en),
    .stage_word (stage_word),
    .div_exp    (div_exp),
    .div_en     (div_en)
);

// File: tb/dcoctl_top_tb_top.sv
// Self-checking bench: it sweeps the stage word across every carry and
// borrow boundary and measures the divide ratio after each exponent change.
module dcoctl_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       lf_valid;
    logic [5:0] lf_step;
    logic       osc_en;
    logic [7:0] stage_word;
    logic [2:0] coarse_sel;
    logic [4:0] fine_cnt;
    logic [3:0] div_exp;
    logic       div_en;
    logic [3:0] ext_exp;
    logic       div2_en;

    int total = 0;
    int bad = 0;
    bit done = 0;
    int osc_mode = 0;
    int phase = 0;
    int en_cnt = 0, last_int = 0, pulses = 0;
    int en2_cnt = 0, last2 = 0, pulses2 = 0;
    int m_stage = 0, m_exp = 0;

    always #10 clk = ~clk;

    dcoctl_top dut_i (
        .clk(clk), .rst_n(rst_n), .lf_valid(lf_valid), .lf_step(lf_step),
        .osc_en(osc_en), .stage_word(stage_word), .coarse_sel(coarse_sel),
        .fine_cnt(fine_cnt), .div_exp(div_exp), .div_en(div_en)
    );

    dcoctl_pow2_div #(.EXP_W(4), .EXP_MAX(9)) div_i (
        .clk(clk), .rst_n(rst_n), .exp_req(ext_exp), .in_en(osc_en), .out_en(div2_en)
    );

    // Drive the oscillator enable at the falling edge, then sample the outputs.
    always begin
        @(negedge clk);
        phase++;
        osc_en = (osc_mode == 1) || (osc_mode == 2 && phase[0]) ||
                 (osc_mode == 3 && (phase % 3 == 0));
        #5;
        if (rst_n) begin
            if (osc_en) begin en_cnt++; en2_cnt++; end
            if (div_en) begin last_int = en_cnt; en_cnt = 0; pulses++; end
            if (div2_en) begin last2 = en2_cnt; en2_cnt = 0; pulses2++; end
        end
    end

    task automatic chk(string tag, int act, int want);
        total++;
        if (act != want) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, want);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    // Apply one loop update, update the model and check the ports.
    task automatic do_step(int s, output string tag);
        int sum;
        @(negedge clk);
        lf_step  = 6'(s);
        lf_valid = 1'b1;
        @(negedge clk);
        lf_valid = 1'b0;
        sum = m_stage + s;
        tag = "R2";
        if (sum > 255) begin
            if (m_exp < 9) begin m_stage = sum - 256; m_exp++; tag = "R3"; end
            else begin m_stage = 255; tag = "R5"; end
        end else if (sum < 0) begin
            if (m_exp > 0) begin m_stage = sum + 256; m_exp--; tag = "R4"; end
            else begin m_stage = 0; tag = "R6"; end
        end else begin
            m_stage = sum;
        end
        chk(tag, int'(stage_word), m_stage);
        chk(tag, int'(div_exp), m_exp);
        chk("R7", int'(coarse_sel), m_stage / 32);
        chk("R7", int'(fine_cnt), m_stage % 32);
    endtask

    // Return the length of the second complete output period, in enables.
    task automatic measure(output int n);
        int p0;
        p0 = pulses;
        wait (pulses >= p0 + 2);
        n = last_int;
    endtask

    initial begin
        int n;
        string tag;
        rst_n = 1'b0; lf_valid = 1'b0; lf_step = '0; ext_exp = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state and divide by one
        chk("R1", int'(stage_word), 0);
        chk("R1", int'(div_exp), 0);
        osc_mode = 1;
        measure(n);
        chk("R1", n, 1);

        // R11: step present without the strobe has no effect
        osc_mode = 0;
        lf_step = 6'd25;
        repeat (4) @(negedge clk);
        chk("R11", int'(stage_word), 0);
        chk("R11", int'(div_exp), 0);

        // R2: in-range steps in both directions
        do_step(13, tag);
        do_step(5, tag);
        do_step(-7, tag);

        // Upward sweep through every carry up to the ceiling (R3, R5, R8)
        for (int k = 0; k < 100; k++) begin
            do_step(31, tag);
            if (tag == "R3") begin
                osc_mode = (m_exp % 3) + 1;
                measure(n);
                chk("R8", n, 1 << m_exp);
            end
        end
        do_step(1, tag);
        chk("R5", int'(stage_word), 255);

        // Downward sweep through every borrow to the floor (R4, R6, R8)
        for (int k = 0; k < 100; k++) begin
            do_step(-32, tag);
            if (tag == "R4") begin
                osc_mode = (m_exp % 3) + 1;
                measure(n);
                chk("R8", n, 1 << m_exp);
            end
        end
        do_step(-5, tag);
        chk("R6", int'(stage_word), 0);

        // R9: a change in the middle of a period applies only after the wrap
        while (m_exp < 3) do_step(31, tag);
        while (m_stage + 31 <= 255) do_step(31, tag);
        osc_mode = 1;
        begin
            int p0;
            p0 = pulses + 1;
            wait (pulses >= p0);
            do_step(31, tag);
            chk("R9", int'(div_exp), 4);
            wait (pulses >= p0 + 1);
            chk("R9", last_int, 8);
            wait (pulses >= p0 + 2);
            chk("R9", last_int, 16);
        end

        // R10: standalone divider swept over every exponent code
        for (int e = 0; e < 16; e++) begin
            int q0;
            @(negedge clk);
            ext_exp = 4'(e);
            q0 = pulses2;
            wait (pulses2 >= q0 + 2);
            chk((e > 9) ? "R10" : "R8", last2, 1 << ((e > 9) ? 9 : e));
        end

        summary();
    end

    // Watchdog: an expired run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
    end

endmodule